// File: doc/BRIEF.md
# SCSI Data Phase Tracker and Transfer Byte Counter

This block sits beside the script sequencer of a host adapter. It keeps the bus phase the adapter last observed and the byte bookkeeping of the current data move. Software or the sequencer loads a start address and a byte count. Each time the transfer engine is granted a chunk, the block works out how many bytes move. That is the smaller of the bytes still owed and the bytes the target has ready. The block then advances the address, lowers the remaining count and adds the chunk to a running total. When the target offers nothing, no bytes move and a wait strobe is given.

The sequencer can ask the block to compare the phase its script expects against the phase seen on the bus. On a difference the block does one of two things. With redirection enabled, it loads one of two programmable jump targets into the script pointer and gives a jump strobe. With redirection disabled, it latches a phase-mismatch interrupt and asks the sequencer to halt. Either way, the phase field takes the phase just observed.

Top module: `scsi_xfer_phase`

## Requirements
- R1: While reset is held, and after it is released, cur_addr, bytes_left, bytes_total, script_ptr, phase_stat and scsi_int_stat are zero, and xfer_done, xfer_wait, jump_taken, halt_req and irq are low.
- R2: A cycle with xfer_load high sets cur_addr to load_addr and bytes_left to load_count on the next edge. bytes_total is not touched. If chunk_go is high in the same cycle, the load takes precedence and no chunk is counted.
- R3: A cycle with chunk_go high and xfer_load low moves n = min(bytes_left, avail_bytes) bytes. cur_addr rises by n, bytes_left falls by n and bytes_total rises by n, all on the next edge.
- R4: When n is zero on a chunk_go cycle, the counters keep their values and xfer_wait pulses high for one cycle.
- R5: xfer_done pulses high for one cycle when a chunk of nonzero size brings bytes_left to zero.
- R6: cur_addr and bytes_total are 32 bits wide and wrap modulo 2^32. bytes_left is 24 bits wide.
- R7: A phase_chk cycle with bus_phase different from expect_phase and mm_jump_en high loads script_ptr with jmp_addr1 if mm_jump_sel or dir_out is high, and with jmp_addr2 otherwise. jump_taken pulses for one cycle, and no interrupt is raised.
- R8: A phase_chk mismatch with mm_jump_en low sets bit 7 (value 0x80) of scsi_int_stat and raises irq. It also pulses halt_req for one cycle and leaves script_ptr unchanged.
- R9: The phase is a 3-bit code in phase_stat[2:0]: data out 0, data in 1, command 2, status 3, message out 6, message in 7, with 4 and 5 reserved. On every mismatch it takes bus_phase and bits [7:3] are kept. Those upper bits change only through stat_wr, which writes stat_upper into them.
- R10: A phase_chk cycle with equal phases changes neither script_ptr nor phase_stat nor scsi_int_stat, and gives no strobe.
- R11: irq_clr clears scsi_int_stat and drops irq on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_load | input | 1 | Load start address and byte count |
| load_addr | input | 32 | Start address for the transfer |
| load_count | input | 24 | Byte count for the transfer |
| chunk_go | input | 1 | Transfer chunk granted this cycle |
| avail_bytes | input | 24 | Bytes the target has ready |
| phase_chk | input | 1 | Compare expected and observed phase |
| expect_phase | input | 3 | Phase the script expects |
| bus_phase | input | 3 | Phase seen on the bus |
| dir_out | input | 1 | Transfer is outbound |
| mm_jump_en | input | 1 | Redirect on mismatch instead of interrupting |
| mm_jump_sel | input | 1 | Force the first jump target |
| jmp_addr1 | input | 32 | First mismatch jump target |
| jmp_addr2 | input | 32 | Second mismatch jump target |
| stat_wr | input | 1 | Write the upper status bits |
| stat_upper | input | 5 | Value for phase_stat[7:3] |
| irq_clr | input | 1 | Clear the mismatch interrupt |
| cur_addr | output | 32 | Current transfer address |
| bytes_left | output | 24 | Remaining byte count |
| bytes_total | output | 32 | Cumulative bytes moved |
| xfer_done | output | 1 | Remaining count reached zero |
| xfer_wait | output | 1 | Chunk granted with nothing to move |
| script_ptr | output | 32 | Script pointer after redirection |
| jump_taken | output | 1 | Mismatch jump strobe |
| halt_req | output | 1 | Request to halt script execution |
| irq | output | 1 | Interrupt request |
| scsi_int_stat | output | 8 | SCSI interrupt status |
| phase_stat | output | 8 | Status register holding the phase field |

## Verification
Every result is registered, so each output answers a strobe exactly one edge later. xfer_done, xfer_wait, jump_taken and halt_req are high only during that cycle. The bench changes inputs on the falling edge, and it reads outputs on the next falling edge, one rising edge later. For the pulse outputs it also reads one cycle later to confirm they have fallen. The chunk table assumes bytes_left, cur_addr and bytes_total carry over from one row to the next, so each row's expectation depends on the one before.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
  localparam int unsigned PH_W   = 3;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned UP_W   = STAT_W - PH_W;

  typedef enum logic [PH_W-1:0] {
    PH_DOUT = 3'd0,
    PH_DIN  = 3'd1,
    PH_CMD  = 3'd2,
    PH_STS  = 3'd3,
    PH_MOUT = 3'd6,
    PH_MIN  = 3'd7
  } phase_e;
endpackage

// File: rtl/xfp_chunk_size.sv
module xfp_chunk_size #(
  parameter int unsigned CNT_W = 24
) (
  input  logic [CNT_W-1:0] left_i,
  input  logic [CNT_W-1:0] avail_i,
  output logic [CNT_W-1:0] size_o,
  output logic             empty_o,
  output logic             last_o
);
  always_comb begin
    size_o  = (avail_i < left_i) ? avail_i : left_i;
    empty_o = (size_o == '0);
    last_o  = !empty_o && (size_o == left_i);
  end
endmodule

// File: rtl/xfp_counters.sv
module xfp_counters #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic              empty_i,
  input  logic              last_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  left_o,
  output logic [ADDR_W-1:0] total_o,
  output logic              done_o,
  output logic              wait_o
);
  localparam int unsigned PAD_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] addr_q, addr_d, total_q, total_d, size_ext;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              done_d, wait_d, done_q, wait_q;
  logic              step;

  assign size_ext = {{PAD_W{1'b0}}, size_i};
  assign step     = go_i && !load_i && !empty_i;

  always_comb begin
    addr_d  = addr_q;
    left_d  = left_q;
    total_d = total_q;
    done_d  = 1'b0;
    wait_d  = 1'b0;
    if (load_i) begin
      addr_d = load_addr_i;
      left_d = load_cnt_i;
    end else if (go_i) begin
      if (empty_i) begin
        wait_d = 1'b1;
      end else begin
        addr_d  = addr_q + size_ext;
        left_d  = left_q - size_i;
        total_d = total_q + size_ext;
        done_d  = last_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      left_q  <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      left_q  <= left_d;
      total_q <= total_d;
      done_q  <= done_d;
      wait_q  <= wait_d;
    end
  end

  assign addr_o  = addr_q;
  assign left_o  = left_q;
  assign total_o = total_q;
  assign done_o  = done_q;
  assign wait_o  = wait_q;

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !load_i && empty_i) |=> (left_q == $past(left_q) && total_q == $past(total_q))); // R4
  AST_LEFT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (left_q <= $past(left_q))); // R3
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (left_q == '0)); // R5
  AST_MOVE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((addr_q - $past(addr_q)) == (total_q - $past(total_q)))); // R3
endmodule

// File: rtl/xfp_phase_ctl.sv
module xfp_phase_ctl
  import xfp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_i,
  input  logic [PH_W-1:0]   expect_i,
  input  logic [PH_W-1:0]   bus_i,
  input  logic              dir_out_i,
  input  logic              jump_en_i,
  input  logic              jump_sel_i,
  input  logic [ADDR_W-1:0] tgt1_i,
  input  logic [ADDR_W-1:0] tgt2_i,
  input  logic              stat_wr_i,
  input  logic [UP_W-1:0]   stat_up_i,
  input  logic              irq_clr_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              jump_o,
  output logic              halt_o,
  output logic              irq_o,
  output logic [STAT_W-1:0] int_stat_o,
  output logic [STAT_W-1:0] stat_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [UP_W-1:0]   up_q, up_d;
  logic              mm_q, mm_d, jump_q, jump_d, halt_q, halt_d;
  logic              miss;

  assign miss = chk_i && (bus_i != expect_i);

  always_comb begin
    ptr_d  = ptr_q;
    ph_d   = ph_q;
    up_d   = up_q;
    mm_d   = mm_q;
    jump_d = 1'b0;
    halt_d = 1'b0;
    if (stat_wr_i) up_d = stat_up_i;
    if (irq_clr_i) mm_d = 1'b0;
    if (miss) begin
      ph_d = bus_i;
      if (jump_en_i) begin
        ptr_d  = (jump_sel_i || dir_out_i) ? tgt1_i : tgt2_i;
        jump_d = 1'b1;
      end else begin
        mm_d   = 1'b1;
        halt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ph_q   <= '0;
      up_q   <= '0;
      mm_q   <= 1'b0;
      jump_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      ph_q   <= ph_d;
      up_q   <= up_d;
      mm_q   <= mm_d;
      jump_q <= jump_d;
      halt_q <= halt_d;
    end
  end

  assign ptr_o      = ptr_q;
  assign jump_o     = jump_q;
  assign halt_o     = halt_q;
  assign irq_o      = mm_q;
  assign int_stat_o = {mm_q, {(STAT_W-1){1'b0}}};
  assign stat_o     = {up_q, ph_q};

  AST_JUMP_XOR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !(jump_q && halt_q)); // R7
  AST_HALT_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> irq_o); // R8
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_i |=> (stat_o[STAT_W-1:PH_W] == $past(stat_o[STAT_W-1:PH_W]))); // R9
  AST_PTR_ONLY_ON_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_q |-> (ptr_q == $past(ptr_q))); // R7
  AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i && bus_i == expect_i) |=> (!jump_q && !halt_q)); // R10
endmodule

// File: rtl/scsi_xfer_phase.sv
module scsi_xfer_phase
  import xfp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              chunk_go,
  input  logic [CNT_W-1:0]  avail_bytes,
  input  logic              phase_chk,
  input  logic [PH_W-1:0]   expect_phase,
  input  logic [PH_W-1:0]   bus_phase,
  input  logic              dir_out,
  input  logic              mm_jump_en,
  input  logic              mm_jump_sel,
  input  logic [ADDR_W-1:0] jmp_addr1,
  input  logic [ADDR_W-1:0] jmp_addr2,
  input  logic              stat_wr,
  input  logic [UP_W-1:0]   stat_upper,
  input  logic              irq_clr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  bytes_left,
  output logic [ADDR_W-1:0] bytes_total,
  output logic              xfer_done,
  output logic              xfer_wait,
  output logic [ADDR_W-1:0] script_ptr,
  output logic              jump_taken,
  output logic              halt_req,
  output logic              irq,
  output logic [STAT_W-1:0] scsi_int_stat,
  output logic [STAT_W-1:0] phase_stat
);
  logic [CNT_W-1:0] size_w;
  logic             empty_w, last_w;

  xfp_chunk_size #(.CNT_W(CNT_W)) u_size (
    .left_i (bytes_left),
    .avail_i(avail_bytes),
    .size_o (size_w),
    .empty_o(empty_w),
    .last_o (last_w)
  );

  xfp_counters #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (xfer_load),
    .load_addr_i(load_addr),
    .load_cnt_i (load_count),
    .go_i       (chunk_go),
    .size_i     (size_w),
    .empty_i    (empty_w),
    .last_i     (last_w),
    .addr_o     (cur_addr),
    .left_o     (bytes_left),
    .total_o    (bytes_total),
    .done_o     (xfer_done),
    .wait_o     (xfer_wait)
  );

  xfp_phase_ctl #(.ADDR_W(ADDR_W)) u_ph (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_i     (phase_chk),
    .expect_i  (expect_phase),
    .bus_i     (bus_phase),
    .dir_out_i (dir_out),
    .jump_en_i (mm_jump_en),
    .jump_sel_i(mm_jump_sel),
    .tgt1_i    (jmp_addr1),
    .tgt2_i    (jmp_addr2),
    .stat_wr_i (stat_wr),
    .stat_up_i (stat_upper),
    .irq_clr_i (irq_clr),
    .ptr_o     (script_ptr),
    .jump_o    (jump_taken),
    .halt_o    (halt_req),
    .irq_o     (irq),
    .int_stat_o(scsi_int_stat),
    .stat_o    (phase_stat)
  );

  AST_NO_DONE_AND_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_wait)); // R4
  AST_IRQ_MIRRORS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (scsi_int_stat != '0)); // R11
endmodule

// File: tb/scsi_xfer_phase_tb.sv
module scsi_xfer_phase_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] avail;
    logic [31:0] e_addr;
    logic [23:0] e_left;
    logic [31:0] e_total;
    logic        e_done;
    logic        e_wait;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{24'd30, 32'h0000_101E, 24'd70, 32'd30,  1'b0, 1'b0},
    '{24'd0,  32'h0000_101E, 24'd70, 32'd30,  1'b0, 1'b1},
    '{24'd50, 32'h0000_1050, 24'd20, 32'd80,  1'b0, 1'b0},
    '{24'd40, 32'h0000_1064, 24'd0,  32'd100, 1'b1, 1'b0},
    '{24'd10, 32'h0000_1064, 24'd0,  32'd100, 1'b0, 1'b1}
  };

  logic clk, rst_n;
  logic xfer_load, chunk_go, phase_chk, dir_out, mm_jump_en, mm_jump_sel, stat_wr, irq_clr;
  logic [31:0] load_addr, jmp_addr1, jmp_addr2;
  logic [23:0] load_count, avail_bytes;
  logic [2:0]  expect_phase, bus_phase;
  logic [4:0]  stat_upper;
  logic [31:0] cur_addr, bytes_total, script_ptr;
  logic [23:0] bytes_left;
  logic        xfer_done, xfer_wait, jump_taken, halt_req, irq;
  logic [7:0]  scsi_int_stat, phase_stat;

  int n_run, n_fail;

  scsi_xfer_phase u_dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    xfer_load = 0; chunk_go = 0; phase_chk = 0; stat_wr = 0; irq_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 0;
    xfer_load = 0; chunk_go = 0; phase_chk = 0; dir_out = 0; mm_jump_en = 0;
    mm_jump_sel = 0; stat_wr = 0; irq_clr = 0; load_addr = 0; jmp_addr1 = 32'hA000;
    jmp_addr2 = 32'hB000; load_count = 0; avail_bytes = 0; expect_phase = 0;
    bus_phase = 0; stat_upper = 0;
    repeat (3) @(negedge clk);
    chk("R1 addr", cur_addr, 0);
    chk("R1 left", {8'd0, bytes_left}, 0);
    chk("R1 ptr", script_ptr, 0);
    chk("R1 flags", {27'd0, xfer_done, xfer_wait, jump_taken, halt_req, irq}, 0);
    rst_n = 1;
    step();
    chk("R1 stat", {16'd0, scsi_int_stat, phase_stat}, 0);
    chk("R1 total", bytes_total, 0);

    // R2: load, with a simultaneous chunk ignored
    xfer_load = 1; load_addr = 32'h1000; load_count = 24'd100;
    chunk_go = 1; avail_bytes = 24'd5;
    step();
    chk("R2 addr", cur_addr, 32'h1000);
    chk("R2 left", {8'd0, bytes_left}, 100);
    chk("R2 total", bytes_total, 0);

    // R3 R4 R5: chunk table
    foreach (TBL[i]) begin
      chunk_go = 1; avail_bytes = TBL[i].avail;
      step();
      chk("R3 addr", cur_addr, TBL[i].e_addr);
      chk("R3 left", {8'd0, bytes_left}, {8'd0, TBL[i].e_left});
      chk("R3 total", bytes_total, TBL[i].e_total);
      chk("R5 done", {31'd0, xfer_done}, {31'd0, TBL[i].e_done});
      chk("R4 wait", {31'd0, xfer_wait}, {31'd0, TBL[i].e_wait});
    end
    step();
    chk("R4 wait pulse ends", {31'd0, xfer_wait}, 0);

    // R6: address wrap
    xfer_load = 1; load_addr = 32'hFFFF_FFF0; load_count = 24'h20;
    step();
    chunk_go = 1; avail_bytes = 24'h40;
    step();
    chk("R6 addr wrap", cur_addr, 32'h0000_0010);
    chk("R6 total", bytes_total, 32'd132);
    chk("R5 done wrap", {31'd0, xfer_done}, 1);
    step();
    chk("R5 done pulse ends", {31'd0, xfer_done}, 0);

    // R7 R9: jump targets
    mm_jump_en = 1; mm_jump_sel = 0; dir_out = 1;
    phase_chk = 1; expect_phase = 3'd2; bus_phase = 3'd1;
    step();
    chk("R7 ptr out", script_ptr, 32'hA000);
    chk("R7 jump", {30'd0, jump_taken, irq}, 2);
    chk("R9 phase", {24'd0, phase_stat}, 1);
    dir_out = 0; phase_chk = 1; expect_phase = 3'd1; bus_phase = 3'd7;
    step();
    chk("R7 ptr in", script_ptr, 32'hB000);
    chk("R9 phase msg in", {24'd0, phase_stat}, 7);
    mm_jump_sel = 1; phase_chk = 1; expect_phase = 3'd0; bus_phase = 3'd3;
    step();
    chk("R7 ptr sel", script_ptr, 32'hA000);
    step();
    chk("R7 jump pulse ends", {31'd0, jump_taken}, 0);

    // R9: upper bits
    stat_wr = 1; stat_upper = 5'b10101;
    step();
    chk("R9 upper", {24'd0, phase_stat}, 32'hAB);

    // R10: match
    phase_chk = 1; expect_phase = 3'd6; bus_phase = 3'd6;
    step();
    chk("R10 stat", {24'd0, phase_stat}, 32'hAB);
    chk("R10 ptr", script_ptr, 32'hA000);
    chk("R10 strobes", {29'd0, jump_taken, halt_req, irq}, 0);

    // R8: interrupt path
    mm_jump_en = 0; phase_chk = 1; expect_phase = 3'd0; bus_phase = 3'd6;
    step();
    chk("R8 int stat", {24'd0, scsi_int_stat}, 32'h80);
    chk("R8 halt irq jump", {29'd0, halt_req, irq, jump_taken}, 6);
    chk("R8 ptr kept", script_ptr, 32'hA000);
    chk("R9 upper kept", {24'd0, phase_stat}, 32'hAE);
    step();
    chk("R8 halt pulse ends", {30'd0, halt_req, irq}, 1);

    // R11
    irq_clr = 1;
    step();
    chk("R11 clear", {23'd0, irq, scsi_int_stat}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule